// File: doc/BRIEF.md
# ECC Control and Error-Status Unit

This unit holds the configuration and error bookkeeping that sit next to a single-error-correct, double-error-detect (SECDED) encoder and decoder in a memory controller datapath. It does not compute any check bits itself. It holds a 32-bit control word. From that word it drives the decoder's correct and detect enables and can flip check bits on the write path so the ECC logic can be tested. It also applies the single-bit and double-bit error pulses that the decoder raises.

For each error class the unit keeps the following:
- a saturating event counter;
- a captured failing address, which holds either the first or the most recent error;
- a lane bitmap with one bit per 64-bit segment of the wide data word.

Software reaches everything through a flat register port. Reads return data in the same cycle. A single interrupt line reports counted errors. The interrupt is a two-state machine. `IRQ_QUIET` moves to `IRQ_RAISED` when a counted error arrives (transition *raise*). `IRQ_RAISED` returns to `IRQ_QUIET` when the control word is written with the interrupt-clear bit and no counted error arrives in that cycle (transition *drop*). In every other case the state holds.

Register selects on `reg_addr`:

| Select | Register |
|---|---|
| 0 | control word |
| 1 | single-bit count |
| 2 | double-bit count |
| 3 | single-bit address |
| 4 | double-bit address |
| 5 | single-bit lane map |
| 6 | double-bit lane map |
| 7 | reads as zero |

Top module: `eccstat_unit`

## Requirements
- R1: The control word resets to 0. Only bits 0, 1, 2, 7, 8, 9 and 10 are stored. Reserved bits 3, 5, 6 and 12 to 31 read as 0. The action bits 4 and 11 are never stored and always read as 0.
- R2: `dec_fix_en` follows control bit 1 and `dec_dbe_en` follows control bit 2.
- R3: A single-bit error pulse is recorded only while control bit 0 is 1. A double-bit error pulse is recorded only while control bit 2 is 1. An unrecorded pulse leaves the counter, the address, the lane map and the interrupt unchanged.
- R4: With control bit 10 at 0, the address register of a class takes the address of every recorded error. With bit 10 at 1, it keeps the first error recorded since reset or since the last clear-all.
- R5: With control bit 8 at 0, `chk_out` equals `chk_in`. With bit 8 at 1 and bit 9 at 0, bit 0 of `chk_out` is inverted. With bits 8 and 9 both at 1, bits 0 and 1 are inverted.
- R6: Each counter stops at its all-ones value and does not wrap.
- R7: While control bit 7 is 1, reading a counter returns its value and then sets that counter to 0.
- R8: Writing the control word with bit 4 at 1 sets both counters and both address registers to 0 and leaves the lane maps untouched. An error recorded in the same cycle is applied after the clear.
- R9: A recorded error sets bit `err_lane` of its class's lane map. Writing a lane map clears each bit written as 1 and leaves the others. If a set and a clear hit the same bit in one cycle, the set wins.
- R10: `irq` rises the cycle after a recorded error and stays high until the control word is written with bit 11 at 1. If a recorded error arrives in that same cycle, `irq` stays high.
- R11: Reads are combinational. A read of a clear-on-read counter returns the value it had before the clear. If an error is recorded in that same cycle, the counter holds 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| err_sbe | input | 1 | Single-bit error pulse from the decoder |
| err_dbe | input | 1 | Double-bit error pulse from the decoder |
| err_addr | input | ADDR_W | Failing address for the pulse |
| err_lane | input | LIDX_W | 64-bit segment index of the failure |
| chk_in | input | CHK_W | Check bits from the encoder |
| chk_out | output | CHK_W | Check bits to memory, possibly corrupted |
| dec_fix_en | output | 1 | Single-bit correction enable to the decoder |
| dec_dbe_en | output | 1 | Double-bit detection enable to the decoder |
| irq | output | 1 | Sticky error interrupt |

## Verification
The risky case is a clear and an error pulse landing in the same cycle. The clear can be a clear-all write, a clear-on-read of a counter, a write-1-to-clear of a lane map, or an interrupt-clear write. The bench drives the register strobe and the error pulse together in one cycle. It then reads the register back, or watches `irq`, and expects the event to have survived the clear: a count of 1, the new address, the lane bit still set, or `irq` still high.

// File: rtl/eccstat_pkg.sv
package eccstat_pkg;

    // control word bit positions (software-visible, so fixed)
    localparam int B_SBE_CNT    = 0;
    localparam int B_SBE_FIX    = 1;
    localparam int B_DBE_EN     = 2;
    localparam int B_CLR_ALL    = 4;
    localparam int B_RD_CLR     = 7;
    localparam int B_INJ_EN     = 8;
    localparam int B_INJ_DBL    = 9;
    localparam int B_KEEP_FIRST = 10;
    localparam int B_IRQ_CLR    = 11;

    localparam int          REG_W      = 32;
    localparam int          RSEL_W     = 3;
    localparam logic [31:0] CTRL_STORE = 32'h0000_0787;

    typedef enum logic [RSEL_W-1:0] {
        RA_CTRL     = 3'd0,
        RA_SBE_CNT  = 3'd1,
        RA_DBE_CNT  = 3'd2,
        RA_SBE_ADDR = 3'd3,
        RA_DBE_ADDR = 3'd4,
        RA_SBE_MAP  = 3'd5,
        RA_DBE_MAP  = 3'd6,
        RA_NONE     = 3'd7
    } reg_sel_e;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

endpackage

// File: rtl/eccstat_ctrl.sv
module eccstat_ctrl
    import eccstat_pkg::*;
#(
    parameter int CHK_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] ctrl_q,
    output logic             clr_all_p,
    output logic             irq_clr_p,
    input  logic [CHK_W-1:0] chk_in,
    output logic [CHK_W-1:0] chk_out
);

    logic [CHK_W-1:0] flip;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wdata & CTRL_STORE;
        end
    end

    // action bits are pulses, never stored
    always_comb begin
        clr_all_p = wr_en && wdata[B_CLR_ALL];
        irq_clr_p = wr_en && wdata[B_IRQ_CLR];
    end

    // write-path corruption: one or two check bits inverted
    always_comb begin
        flip = '0;
        if (ctrl_q[B_INJ_EN]) begin
            flip[0] = 1'b1;
            if (ctrl_q[B_INJ_DBL]) begin
                flip[1] = 1'b1;
            end
        end
        chk_out = chk_in ^ flip;
    end

endmodule

// File: rtl/eccstat_errlog.sv
module eccstat_errlog #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int LANES  = 32,
    parameter int LIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [LIDX_W-1:0] evt_lane,
    input  logic              keep_first,
    input  logic              clr_all,
    input  logic              rd_clr,
    input  logic              map_clr_en,
    input  logic [LANES-1:0]  map_clr_mask,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  map_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic              held_q;
    logic [CNT_W-1:0]  cnt_base, cnt_nx;
    logic [ADDR_W-1:0] addr_nx;
    logic              held_base, held_nx;
    logic [LANES-1:0]  lane_hit, map_nx;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign lane_hit[i] = evt && (evt_lane == LIDX_W'(i));
        end
    endgenerate

    // clears apply first, then the event of the same cycle
    always_comb begin
        cnt_base = (clr_all || rd_clr) ? '0 : cnt_q;
        cnt_nx   = cnt_base;
        if (evt && (cnt_base != CNT_MAX)) begin
            cnt_nx = cnt_base + 1'b1;
        end

        held_base = clr_all ? 1'b0 : held_q;
        addr_nx   = clr_all ? '0 : addr_q;
        held_nx   = held_base;
        if (evt) begin
            held_nx = 1'b1;
            if (!(keep_first && held_base)) begin
                addr_nx = evt_addr;
            end
        end

        map_nx = (map_q & ~(map_clr_en ? map_clr_mask : '0)) | lane_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
            held_q <= 1'b0;
            map_q  <= '0;
        end else begin
            cnt_q  <= cnt_nx;
            addr_q <= addr_nx;
            held_q <= held_nx;
            map_q  <= map_nx;
        end
    end

endmodule

// File: rtl/eccstat_irq.sv
module eccstat_irq
    import eccstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic raise,
    input  logic drop,
    output logic irq
);

    irq_state_e state_q, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (raise)          state_nx = IRQ_RAISED;
            IRQ_RAISED: if (drop && !raise) state_nx = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq = (state_q == IRQ_RAISED);
    end

endmodule

// File: rtl/eccstat_unit.sv
module eccstat_unit
    import eccstat_pkg::*;
#(
    parameter  int ADDR_W = 32,
    parameter  int CNT_W  = 32,
    parameter  int LANES  = 32,
    parameter  int CHK_W  = 8,
    localparam int LIDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              err_sbe,
    input  logic              err_dbe,
    input  logic [ADDR_W-1:0] err_addr,
    input  logic [LIDX_W-1:0] err_lane,
    input  logic [CHK_W-1:0]  chk_in,
    output logic [CHK_W-1:0]  chk_out,
    output logic              dec_fix_en,
    output logic              dec_dbe_en,
    output logic              irq
);

    logic [REG_W-1:0]  ctrl_q;
    logic              clr_all_p, irq_clr_p;
    logic              ctrl_wr, sbe_evt, dbe_evt;
    logic              sbe_rdclr, dbe_rdclr, sbe_mapwr, dbe_mapwr;
    logic [CNT_W-1:0]  sbe_cnt, dbe_cnt;
    logic [ADDR_W-1:0] sbe_addr, dbe_addr;
    logic [LANES-1:0]  sbe_map, dbe_map;

    always_comb begin
        ctrl_wr   = reg_wr && (reg_addr == RA_CTRL);
        sbe_evt   = err_sbe && ctrl_q[B_SBE_CNT];
        dbe_evt   = err_dbe && ctrl_q[B_DBE_EN];
        sbe_rdclr = reg_rd && (reg_addr == RA_SBE_CNT) && ctrl_q[B_RD_CLR];
        dbe_rdclr = reg_rd && (reg_addr == RA_DBE_CNT) && ctrl_q[B_RD_CLR];
        sbe_mapwr = reg_wr && (reg_addr == RA_SBE_MAP);
        dbe_mapwr = reg_wr && (reg_addr == RA_DBE_MAP);
        dec_fix_en = ctrl_q[B_SBE_FIX];
        dec_dbe_en = ctrl_q[B_DBE_EN];
    end

    eccstat_ctrl #(.CHK_W(CHK_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctrl_wr),
        .wdata     (reg_wdata),
        .ctrl_q    (ctrl_q),
        .clr_all_p (clr_all_p),
        .irq_clr_p (irq_clr_p),
        .chk_in    (chk_in),
        .chk_out   (chk_out)
    );

    eccstat_errlog #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LANES(LANES), .LIDX_W(LIDX_W)
    ) u_sbe_log (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (sbe_evt),
        .evt_addr     (err_addr),
        .evt_lane     (err_lane),
        .keep_first   (ctrl_q[B_KEEP_FIRST]),
        .clr_all      (clr_all_p),
        .rd_clr       (sbe_rdclr),
        .map_clr_en   (sbe_mapwr),
        .map_clr_mask (reg_wdata[LANES-1:0]),
        .cnt_q        (sbe_cnt),
        .addr_q       (sbe_addr),
        .map_q        (sbe_map)
    );

    eccstat_errlog #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LANES(LANES), .LIDX_W(LIDX_W)
    ) u_dbe_log (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (dbe_evt),
        .evt_addr     (err_addr),
        .evt_lane     (err_lane),
        .keep_first   (ctrl_q[B_KEEP_FIRST]),
        .clr_all      (clr_all_p),
        .rd_clr       (dbe_rdclr),
        .map_clr_en   (dbe_mapwr),
        .map_clr_mask (reg_wdata[LANES-1:0]),
        .cnt_q        (dbe_cnt),
        .addr_q       (dbe_addr),
        .map_q        (dbe_map)
    );

    eccstat_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .raise (sbe_evt || dbe_evt),
        .drop  (irq_clr_p),
        .irq   (irq)
    );

    always_comb begin
        unique case (reg_sel_e'(reg_addr))
            RA_CTRL:     reg_rdata = ctrl_q;
            RA_SBE_CNT:  reg_rdata = REG_W'(sbe_cnt);
            RA_DBE_CNT:  reg_rdata = REG_W'(dbe_cnt);
            RA_SBE_ADDR: reg_rdata = REG_W'(sbe_addr);
            RA_DBE_ADDR: reg_rdata = REG_W'(dbe_addr);
            RA_SBE_MAP:  reg_rdata = REG_W'(sbe_map);
            RA_DBE_MAP:  reg_rdata = REG_W'(dbe_map);
            RA_NONE:     reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/eccstat_chk.sv
module eccstat_chk #(
    parameter int CNT_W = 32,
    parameter int CHK_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [2:0]       reg_addr,
    input logic             wd_clr_all,
    input logic             wd_irq_clr,
    input logic [31:0]      reg_rdata,
    input logic             err_sbe,
    input logic             c_cnt_en,
    input logic             c_rd_clr,
    input logic             c_inj_en,
    input logic             c_inj_dbl,
    input logic [CHK_W-1:0] chk_in,
    input logic [CHK_W-1:0] chk_out,
    input logic             irq,
    input logic [CNT_W-1:0] sbe_cnt
);

    logic ctl_w, clr_all_w, irq_clr_w, rd_clr_w, sbe_rec;
    localparam logic [CNT_W-1:0] SAT = '1;

    always_comb begin
        ctl_w     = reg_wr && (reg_addr == 3'd0);
        clr_all_w = ctl_w && wd_clr_all;
        irq_clr_w = ctl_w && wd_irq_clr;
        rd_clr_w  = reg_rd && (reg_addr == 3'd1) && c_rd_clr;
        sbe_rec   = err_sbe && c_cnt_en;
    end

    // R1
    ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 3'd0) |-> ((reg_rdata & ~32'h0000_0787) == 32'h0));

    // R3
    sbe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sbe && !c_cnt_en && !clr_all_w && !rd_clr_w) |=> $stable(sbe_cnt));

    // R5
    inj_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chk_out ^ chk_in) == (c_inj_en ? (c_inj_dbl ? 2 : 1) : 0));

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sbe_cnt == SAT && !clr_all_w && !rd_clr_w) |=> (sbe_cnt == SAT));

    // R8
    clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all_w && !sbe_rec) |=> (sbe_cnt == '0));

    // R10
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sbe_rec |=> irq);

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr_w) |=> irq);

endmodule

bind eccstat_unit eccstat_chk #(.CNT_W(CNT_W), .CHK_W(CHK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_addr   (reg_addr),
    .wd_clr_all (reg_wdata[4]),
    .wd_irq_clr (reg_wdata[11]),
    .reg_rdata  (reg_rdata),
    .err_sbe    (err_sbe),
    .c_cnt_en   (ctrl_q[0]),
    .c_rd_clr   (ctrl_q[7]),
    .c_inj_en   (ctrl_q[8]),
    .c_inj_dbl  (ctrl_q[9]),
    .chk_in     (chk_in),
    .chk_out    (chk_out),
    .irq        (irq),
    .sbe_cnt    (sbe_cnt)
);

// File: tb/eccstat_unit_tb.sv
module eccstat_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        err_sbe = 1'b0, err_dbe = 1'b0;
    logic [15:0] err_addr = '0;
    logic [4:0]  err_lane = '0;
    logic [7:0]  chk_in = 8'hA5;
    logic [7:0]  chk_out;
    logic        dec_fix_en, dec_dbe_en, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    eccstat_unit #(.ADDR_W(16), .CNT_W(4), .LANES(32), .CHK_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_sbe(err_sbe), .err_dbe(err_dbe),
        .err_addr(err_addr), .err_lane(err_lane),
        .chk_in(chk_in), .chk_out(chk_out),
        .dec_fix_en(dec_fix_en), .dec_dbe_en(dec_dbe_en), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, applied at the falling edge
    task automatic cyc(bit wr, bit rd, logic [2:0] a, logic [31:0] wd,
                       bit sbe, bit dbe, logic [15:0] ea, logic [4:0] ln);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        err_sbe = sbe; err_dbe = dbe; err_addr = ea; err_lane = ln;
    endtask

    task automatic idle();
        cyc(0, 0, 3'd0, 32'h0, 0, 0, 16'h0, 5'd0);
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] wd);
        cyc(1, 0, a, wd, 0, 0, 16'h0, 5'd0);
    endtask

    task automatic sbe(logic [15:0] ea, logic [4:0] ln);
        cyc(0, 0, 3'd0, 32'h0, 1, 0, ea, ln);
    endtask

    task automatic dbe(logic [15:0] ea, logic [4:0] ln);
        cyc(0, 0, 3'd0, 32'h0, 0, 1, ea, ln);
    endtask

    // driver: pushes the expected read value for the monitor
    task automatic rd(logic [2:0] a, logic [31:0] exp, string tag, bit with_sbe = 0,
                      logic [4:0] ln = 5'd0);
        cyc(0, 1, a, 32'h0, with_sbe, 0, 16'h0999, ln);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // after one idle cycle, look at the registered outputs
    task automatic look(string tag, logic [31:0] act_sel, logic [31:0] exp);
        check(tag, act_sel, exp);
    endtask

    // monitor: compares each read as the design returns it
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (reg_rd) begin
                if (exp_q.size() == 0) begin
                    check("scoreboard empty", 32'h1, 32'h0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, reg_rdata, e);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        rd(3'd0, 32'h0, "R1 ctrl reset value");
        rd(3'd1, 32'h0, "R1 sbe counter reset value");
        idle(); #4; look("R10 irq low after reset", {31'b0, irq}, 32'h0);

        // every bit written: only stored bits survive
        wr(3'd0, 32'h0000_0FFF);
        rd(3'd0, 32'h0000_0787, "R1 reserved and action bits read 0");
        idle(); #4;
        look("R2 dec_fix_en", {31'b0, dec_fix_en}, 32'h1);
        look("R2 dec_dbe_en", {31'b0, dec_dbe_en}, 32'h1);
        look("R5 double corruption", {24'b0, chk_out}, 32'h0000_00A6);

        wr(3'd0, 32'h0000_0107);
        idle(); #4;
        look("R5 single corruption", {24'b0, chk_out}, 32'h0000_00A4);

        // last-error mode
        sbe(16'h0111, 5'd3);
        idle(); #4; look("R10 irq after counted sbe", {31'b0, irq}, 32'h1);
        sbe(16'h0222, 5'd5);
        rd(3'd1, 32'd2, "R3 sbe count");
        rd(3'd3, 32'h0222, "R4 last address kept");
        rd(3'd5, 32'h0000_0028, "R9 sbe lane map");

        // irq clear with a same-cycle event keeps irq
        cyc(1, 0, 3'd0, 32'h0000_0907, 1, 0, 16'h02AA, 5'd5);
        idle(); #4; look("R10 clear vs event keeps irq", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h0000_0907);
        idle(); #4; look("R10 irq cleared", {31'b0, irq}, 32'h0);
        rd(3'd0, 32'h0000_0107, "R1 irq-clear bit not stored");

        // first-error mode with clear-all
        wr(3'd0, 32'h0000_0517);
        rd(3'd1, 32'd0, "R8 clear-all zeroes count");
        rd(3'd3, 32'h0, "R8 clear-all zeroes address");
        sbe(16'h0333, 5'd3);
        sbe(16'h0444, 5'd5);
        rd(3'd1, 32'd2, "R3 sbe count after clear");
        rd(3'd3, 32'h0333, "R4 first address kept");
        dbe(16'h0555, 5'd7);
        dbe(16'h0666, 5'd7);
        rd(3'd2, 32'd2, "R3 dbe count");
        rd(3'd4, 32'h0555, "R4 first dbe address");
        rd(3'd6, 32'h0000_0080, "R9 dbe lane map");

        // write-1-to-clear and set-wins
        wr(3'd5, 32'h0000_0008);
        rd(3'd5, 32'h0000_0020, "R9 w1c clears only written ones");
        cyc(1, 0, 3'd5, 32'h0000_0020, 1, 0, 16'h0888, 5'd5);
        rd(3'd5, 32'h0000_0020, "R9 set wins over clear");
        rd(3'd1, 32'd3, "R3 count with map write");
        rd(3'd3, 32'h0333, "R4 first address unchanged");

        // clear-all and event in one cycle
        cyc(1, 0, 3'd0, 32'h0000_0517, 1, 0, 16'h0777, 5'd1);
        rd(3'd1, 32'd1, "R8 event after clear counted");
        rd(3'd3, 32'h0777, "R8 event after clear captured");
        rd(3'd2, 32'd0, "R8 dbe count cleared");
        rd(3'd4, 32'h0, "R8 dbe address cleared");
        rd(3'd5, 32'h0000_0022, "R8 lane map untouched");

        // clear-on-read
        wr(3'd0, 32'h0000_0587);
        rd(3'd1, 32'd1, "R7 read returns value");
        rd(3'd1, 32'd0, "R7 counter cleared by read");
        sbe(16'h0999, 5'd1);
        rd(3'd1, 32'd1, "R11 read with event returns old value", 1, 5'd1);
        rd(3'd1, 32'd1, "R11 event after read-clear counted");
        rd(3'd1, 32'd0, "R7 cleared again");

        // everything disabled: pulses ignored
        wr(3'd0, 32'h0000_0800);
        idle(); #4; look("R10 irq cleared again", {31'b0, irq}, 32'h0);
        cyc(0, 0, 3'd0, 32'h0, 1, 1, 16'h0AAA, 5'd9);
        idle(); #4;
        look("R3 gated events raise no irq", {31'b0, irq}, 32'h0);
        look("R5 no corruption", {24'b0, chk_out}, 32'h0000_00A5);
        look("R2 correction disabled", {31'b0, dec_fix_en}, 32'h0);
        rd(3'd1, 32'd0, "R3 sbe count unchanged");
        rd(3'd2, 32'd0, "R3 dbe count unchanged");
        rd(3'd5, 32'h0000_0022, "R3 sbe map unchanged");
        rd(3'd6, 32'h0000_0080, "R3 dbe map unchanged");

        // only double-bit detection enabled
        wr(3'd0, 32'h0000_0004);
        sbe(16'h0BBB, 5'd2);
        idle(); #4; look("R3 uncounted sbe no irq", {31'b0, irq}, 32'h0);
        dbe(16'h0CCC, 5'd4);
        idle(); #4; look("R10 irq on dbe", {31'b0, irq}, 32'h1);
        rd(3'd6, 32'h0000_0090, "R9 dbe lane 4 set");
        rd(3'd2, 32'd1, "R3 dbe counted");

        // saturation
        wr(3'd0, 32'h0000_0001);
        for (int i = 0; i < 17; i++) sbe(16'h0100, 5'd0);
        rd(3'd1, 32'd15, "R6 counter saturates");
        sbe(16'h0100, 5'd0);
        rd(3'd1, 32'd15, "R6 counter stays saturated");

        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, 32'h0, "R9 dbe map fully cleared");
        idle();
        idle();

        if (exp_q.size() != 0) check("scoreboard drained", exp_q.size(), 32'h0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule